// File: doc/BRIEF.md
# Interrupt and power-down controller

This block sequences the interrupt line and the system supply control of a timekeeping device. Three event sources feed it: a power-fail strobe from the line-sense detector, an alarm match strobe from the time comparator, and a periodic tick that the divider chain has already selected. Each event sets a sticky flag in an 8-bit status register. An enabled flag pulls the active-low interrupt line low, and the line stays low until software reads the status register. The read returns the flags and clears them. An event that lands in the same cycle as the read is kept for the next read.

The alarm flag does not set on the match itself. A down-counter first delays it by a number of clock cycles that depends on the selected oscillator frequency. The block also owns the supply-enable output. A write to the interrupt-control register with the power-down bit set drops the supply enable and enters power-down. Either an enabled interrupt event or a supply-restored strobe leaves power-down and raises the supply enable again.

Two control registers share one write port. The interrupt-control register (select 0) holds bit 6 power-down request, bit 5 power-sense enable, bit 4 alarm interrupt enable and bits 3:0 periodic select (non-zero enables the periodic interrupt). The clock-control register (select 1) holds bit 6 line timebase and bits 5:4 oscillator select.

Top module: `wake_irq_ctrl`

## Requirements
- R1: Reset clears both control registers. It sets the status register to 8'h10 (first-time-up flag in bit 4), releases the interrupt line, clears the power-down flag and loads the supply enable from `supply_hi_i`.
- R2: A `tick_i` strobe sets status bit 0 one edge later. The interrupt line is pulled low only if interrupt-control bits 3:0 are non-zero.
- R3: A `pfail_i` strobe sets status bit 2 and pulls the interrupt line low only when interrupt-control bit 5 is 1 and clock-control bit 6 is 0. Otherwise the status register is unchanged.
- R4: An alarm match sets status bit 1 exactly N edges after the edge that samples the match. N is `DLY_4M` for clock-control bits 5:4 = 00, `DLY_2M` for 01 and `DLY_32K` for 1x. The alarm pulls the interrupt line low when interrupt-control bit 4 is 1.
- R5: Once pulled low, the interrupt line stays low until a status read. The read clears every status bit, bit 4 included, at the edge that samples `stat_rd_i`.
- R6: An event sampled in the same cycle as a status read is not lost. Its flag is set after that edge.
- R7: Writing the interrupt-control register with bit 6 = 1 sets `pdown_o` and clears `pse_o` at the next edge. The supply enable is never high while in power-down.
- R8: An enabled interrupt event leaves power-down and sets `pse_o` at the same edge that sets its flag. A disabled event does not leave power-down.
- R9: A `supply_ok_i` strobe leaves power-down and sets `pse_o` at the next edge.
- R10: When a wake source and a power-down write arrive in the same cycle, the wake takes priority and power-down is not entered.
- R11: Status bits 3, 5, 6 and 7 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| supply_hi_i | input | 1 | System supply level, sampled at reset for the supply enable |
| pfail_i | input | 1 | Power-fail strobe from line sensing |
| alarm_match_i | input | 1 | Alarm comparator match strobe |
| tick_i | input | 1 | Selected periodic interval strobe |
| supply_ok_i | input | 1 | System supply restored strobe |
| stat_rd_i | input | 1 | Status register read strobe (read-and-clear) |
| ctl_wr_i | input | 1 | Control register write strobe |
| ctl_sel_i | input | 1 | Write target: 0 interrupt control, 1 clock control |
| ctl_wdata_i | input | RW | Control register write data |
| irq_pull_o | output | 1 | Interrupt open-drain enable, 1 pulls the line low |
| pse_o | output | 1 | Power-supply enable |
| pdown_o | output | 1 | Power-down state flag |
| status_o | output | RW | Status flags, valid before a read |

## Verification
The assertions assume that every strobe input is a single-cycle pulse sampled on the rising edge. They also assume that `supply_hi_i` is steady around the reset edge. The interrupt-hold property further assumes that no control write changes the enable mask in the same cycle. The bench drives each strobe for exactly one cycle at the falling edge. It keeps `supply_hi_i` constant through each reset, and it never issues a control write together with a read when checking that the line holds. Collisions between events are driven on purpose only where R6 and R10 define the outcome.

// File: rtl/wake_irq_pkg.sv
package wake_irq_pkg;

  // Status register bit positions (event index equals bit position)
  localparam int NUM_EVT  = 3;
  localparam int ST_PER   = 0;
  localparam int ST_ALM   = 1;
  localparam int ST_PWR   = 2;
  localparam int ST_FTU   = 4;

  // Interrupt-control fields
  localparam int ICR_PDOWN  = 6;
  localparam int ICR_PSENSE = 5;
  localparam int ICR_ALMEN  = 4;
  localparam int ICR_PER_W  = 4;

  // Clock-control fields
  localparam int CCR_LINE    = 6;
  localparam int CCR_OSC_LSB = 4;

  typedef enum logic [1:0] {
    OSC_4M   = 2'b00,
    OSC_2M   = 2'b01,
    OSC_32K  = 2'b10,
    OSC_32KB = 2'b11
  } osc_sel_e;

endpackage

// File: rtl/alarm_delay_tmr.sv
module alarm_delay_tmr
  import wake_irq_pkg::*;
#(
  parameter int DLY_4M  = 3,
  parameter int DLY_2M  = 6,
  parameter int DLY_32K = 12
) (
  input  logic     clk,
  input  logic     rst,
  input  osc_sel_e osc_sel_i,
  input  logic     match_i,
  output logic     fire_o
);

  localparam int MAXD = (DLY_32K > DLY_2M) ? ((DLY_32K > DLY_4M) ? DLY_32K : DLY_4M)
                                           : ((DLY_2M > DLY_4M) ? DLY_2M : DLY_4M);
  localparam int CW   = $clog2(MAXD + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] load_val;

  always_comb begin
    unique case (osc_sel_i)
      OSC_4M:  load_val = CW'(DLY_4M);
      OSC_2M:  load_val = CW'(DLY_2M);
      default: load_val = CW'(DLY_32K);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (match_i) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign fire_o = (cnt_q == CW'(1));

  // R4: a match always arms the counter
  p_load_r4: assert property (@(posedge clk) disable iff (rst)
    match_i |=> (cnt_q != '0));

  // R4: without a reload the expiry pulse lasts one cycle
  p_fire_single_r4: assert property (@(posedge clk) disable iff (rst)
    (fire_o && !match_i) |=> !fire_o);

endmodule

// File: rtl/evt_status_reg.sv
module evt_status_reg
  import wake_irq_pkg::*;
#(
  parameter int RW = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_EVT-1:0] set_i,
  input  logic [NUM_EVT-1:0] mask_i,
  input  logic               rd_i,
  output logic [RW-1:0]      status_o,
  output logic               irq_o
);

  logic [NUM_EVT-1:0] evt_q;
  logic               ftu_q;

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst) begin
        evt_q[i] <= 1'b0;
      end else begin
        evt_q[i] <= (rd_i ? 1'b0 : evt_q[i]) | set_i[i];
      end
    end

    // R6: an event colliding with a read stays pending
    p_pending_r6: assert property (@(posedge clk) disable iff (rst)
      (rd_i && set_i[i]) |=> status_o[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ftu_q <= 1'b1;
    end else if (rd_i) begin
      ftu_q <= 1'b0;
    end
  end

  always_comb begin
    status_o                = '0;
    status_o[NUM_EVT-1:0]   = evt_q;
    status_o[ST_FTU]        = ftu_q;
  end

  assign irq_o = |(evt_q & mask_i);

  // R5: a read with no new event empties the register
  p_rd_clear_r5: assert property (@(posedge clk) disable iff (rst)
    (rd_i && (set_i == '0)) |=> (status_o == '0));

endmodule

// File: rtl/pwr_down_ctl.sv
module pwr_down_ctl (
  input  logic clk,
  input  logic rst,
  input  logic supply_hi_i,
  input  logic enter_i,
  input  logic wake_i,
  output logic pse_o,
  output logic pdown_o
);

  logic pdown_q;
  logic pse_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pdown_q <= 1'b0;
      pse_q   <= supply_hi_i;
    end else if (wake_i) begin
      pdown_q <= 1'b0;
      pse_q   <= 1'b1;
    end else if (enter_i) begin
      pdown_q <= 1'b1;
      pse_q   <= 1'b0;
    end
  end

  assign pse_o   = pse_q;
  assign pdown_o = pdown_q;

  // R7: entry drops the supply enable
  p_enter_r7: assert property (@(posedge clk) disable iff (rst)
    (enter_i && !wake_i) |=> (pdown_o && !pse_o));

  // R7: supply enable and power-down are exclusive
  p_excl_r7: assert property (@(posedge clk) disable iff (rst)
    pdown_o |-> !pse_o);

  // R8 R9 R10: any wake source ends power-down
  p_wake_r10: assert property (@(posedge clk) disable iff (rst)
    wake_i |=> (!pdown_o && pse_o));

endmodule

// File: rtl/wake_irq_ctrl.sv
module wake_irq_ctrl
  import wake_irq_pkg::*;
#(
  parameter int DLY_4M  = 3,
  parameter int DLY_2M  = 6,
  parameter int DLY_32K = 12,
  parameter int RW      = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          supply_hi_i,
  input  logic          pfail_i,
  input  logic          alarm_match_i,
  input  logic          tick_i,
  input  logic          supply_ok_i,
  input  logic          stat_rd_i,
  input  logic          ctl_wr_i,
  input  logic          ctl_sel_i,
  input  logic [RW-1:0] ctl_wdata_i,
  output logic          irq_pull_o,
  output logic          pse_o,
  output logic          pdown_o,
  output logic [RW-1:0] status_o
);

  logic [RW-1:0]      icr_q;
  logic [RW-1:0]      ccr_q;
  logic               alm_fire;
  logic               pf_en;
  logic               enter;
  logic               wake;
  logic [NUM_EVT-1:0] evt_set;
  logic [NUM_EVT-1:0] evt_mask;
  osc_sel_e           osc_sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      icr_q <= '0;
      ccr_q <= '0;
    end else if (ctl_wr_i) begin
      if (!ctl_sel_i) begin
        icr_q            <= ctl_wdata_i;
        icr_q[ICR_PDOWN] <= 1'b0;
      end else begin
        ccr_q <= ctl_wdata_i;
      end
    end
  end

  assign osc_sel = osc_sel_e'(ccr_q[CCR_OSC_LSB +: 2]);
  assign pf_en   = icr_q[ICR_PSENSE] & ~ccr_q[CCR_LINE];
  assign enter   = ctl_wr_i & ~ctl_sel_i & ctl_wdata_i[ICR_PDOWN];

  always_comb begin
    evt_set          = '0;
    evt_set[ST_PER]  = tick_i;
    evt_set[ST_ALM]  = alm_fire;
    evt_set[ST_PWR]  = pfail_i & pf_en;
    evt_mask         = '0;
    evt_mask[ST_PER] = |icr_q[ICR_PER_W-1:0];
    evt_mask[ST_ALM] = icr_q[ICR_ALMEN];
    evt_mask[ST_PWR] = icr_q[ICR_PSENSE];
  end

  assign wake = (|(evt_set & evt_mask)) | supply_ok_i;

  alarm_delay_tmr #(
    .DLY_4M (DLY_4M),
    .DLY_2M (DLY_2M),
    .DLY_32K(DLY_32K)
  ) u_alm (
    .clk      (clk),
    .rst      (rst),
    .osc_sel_i(osc_sel),
    .match_i  (alarm_match_i),
    .fire_o   (alm_fire)
  );

  evt_status_reg #(
    .RW(RW)
  ) u_stat (
    .clk     (clk),
    .rst     (rst),
    .set_i   (evt_set),
    .mask_i  (evt_mask),
    .rd_i    (stat_rd_i),
    .status_o(status_o),
    .irq_o   (irq_pull_o)
  );

  pwr_down_ctl u_pwr (
    .clk        (clk),
    .rst        (rst),
    .supply_hi_i(supply_hi_i),
    .enter_i    (enter),
    .wake_i     (wake),
    .pse_o      (pse_o),
    .pdown_o    (pdown_o)
  );

  // R5: the line holds until a read (mask held steady)
  p_irq_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (irq_pull_o && !stat_rd_i && !ctl_wr_i) |=> irq_pull_o);

  // R3: no power-fail flag without qualified sensing
  p_pfail_gate_r3: assert property (@(posedge clk) disable iff (rst)
    (!pf_en && !status_o[ST_PWR]) |=> !status_o[ST_PWR]);

endmodule

// File: tb/sim_wake_irq_ctrl.sv
module sim_wake_irq_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int D4M  = 3;
  localparam int D2M  = 6;
  localparam int D32K = 12;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       supply_hi_i = 1'b1;
  logic       pfail_i = 1'b0;
  logic       alarm_match_i = 1'b0;
  logic       tick_i = 1'b0;
  logic       supply_ok_i = 1'b0;
  logic       stat_rd_i = 1'b0;
  logic       ctl_wr_i = 1'b0;
  logic       ctl_sel_i = 1'b0;
  logic [7:0] ctl_wdata_i = 8'h00;
  logic       irq_pull_o;
  logic       pse_o;
  logic       pdown_o;
  logic [7:0] status_o;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wake_irq_ctrl #(
    .DLY_4M(D4M), .DLY_2M(D2M), .DLY_32K(D32K), .RW(8)
  ) u0 (
    .clk(clk), .rst(rst), .supply_hi_i(supply_hi_i), .pfail_i(pfail_i),
    .alarm_match_i(alarm_match_i), .tick_i(tick_i), .supply_ok_i(supply_ok_i),
    .stat_rd_i(stat_rd_i), .ctl_wr_i(ctl_wr_i), .ctl_sel_i(ctl_sel_i),
    .ctl_wdata_i(ctl_wdata_i), .irq_pull_o(irq_pull_o), .pse_o(pse_o),
    .pdown_o(pdown_o), .status_o(status_o)
  );

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic hi);
    supply_hi_i = hi;
    rst = 1'b1;
    cyc(); cyc();
    rst = 1'b0;
    cyc();
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    ctl_wr_i = 1'b1; ctl_sel_i = sel; ctl_wdata_i = d;
    cyc();
    ctl_wr_i = 1'b0; ctl_sel_i = 1'b0; ctl_wdata_i = 8'h00;
  endtask

  task automatic rd();
    stat_rd_i = 1'b1;
    cyc();
    stat_rd_i = 1'b0;
  endtask

  task automatic t_reset();
    do_reset(1'b1);
    check("R1 status", status_o, 8'h10);
    check("R1 irq", irq_pull_o, 0);
    check("R1 pse", pse_o, 1);
    check("R1 pdown", pdown_o, 0);
    do_reset(1'b0);
    check("R1 pse low supply", pse_o, 0);
    rd();
    check("R5 ftu cleared", status_o, 8'h00);
  endtask

  task automatic t_periodic();
    do_reset(1'b1); rd();
    tick_i = 1'b1; cyc(); tick_i = 1'b0;
    check("R2 flag masked", status_o, 8'h01);
    check("R2 irq masked", irq_pull_o, 0);
    rd();
    wr(1'b0, 8'h03);
    tick_i = 1'b1; cyc(); tick_i = 1'b0;
    check("R2 flag enabled", status_o, 8'h01);
    check("R2 irq enabled", irq_pull_o, 1);
    cyc(); cyc(); cyc();
    check("R5 irq held", irq_pull_o, 1);
    rd();
    check("R5 read clears", status_o, 8'h00);
    check("R5 irq released", irq_pull_o, 0);
  endtask

  task automatic t_pfail();
    do_reset(1'b1); rd();
    wr(1'b0, 8'h20); wr(1'b1, 8'h40);
    pfail_i = 1'b1; cyc(); pfail_i = 1'b0;
    check("R3 line timebase blocks", status_o, 8'h00);
    check("R3 irq blocked", irq_pull_o, 0);
    wr(1'b1, 8'h00);
    pfail_i = 1'b1; cyc(); pfail_i = 1'b0;
    check("R3 sensed", status_o, 8'h04);
    check("R3 irq", irq_pull_o, 1);
    rd();
    wr(1'b0, 8'h00);
    pfail_i = 1'b1; cyc(); pfail_i = 1'b0;
    check("R3 sense off", status_o, 8'h00);
  endtask

  task automatic t_alarm();
    int dly [3] = '{D4M, D2M, D32K};
    do_reset(1'b1); rd();
    wr(1'b0, 8'h10);
    for (int m = 0; m < 3; m++) begin
      wr(1'b1, 8'(m << 4));
      alarm_match_i = 1'b1; cyc(); alarm_match_i = 1'b0;
      for (int k = 0; k < dly[m] - 1; k++) cyc();
      check($sformatf("R4 early mode %0d", m), status_o[1], 0);
      cyc();
      check($sformatf("R4 set mode %0d", m), status_o[1], 1);
      check($sformatf("R4 irq mode %0d", m), irq_pull_o, 1);
      rd();
    end
  endtask

  task automatic t_pending();
    do_reset(1'b1); rd();
    wr(1'b0, 8'h21);
    pfail_i = 1'b1; cyc(); pfail_i = 1'b0;
    check("R6 before read", status_o, 8'h04);
    stat_rd_i = 1'b1; tick_i = 1'b1; cyc(); stat_rd_i = 1'b0; tick_i = 1'b0;
    check("R6 pending kept", status_o, 8'h01);
    check("R6 irq kept", irq_pull_o, 1);
    rd();
  endtask

  task automatic t_pdown();
    do_reset(1'b1); rd();
    wr(1'b0, 8'h4F);
    check("R7 pdown", pdown_o, 1);
    check("R7 pse off", pse_o, 0);
    cyc();
    check("R7 pdown held", pdown_o, 1);
    tick_i = 1'b1; cyc(); tick_i = 1'b0;
    check("R8 wake pdown", pdown_o, 0);
    check("R8 wake pse", pse_o, 1);
    check("R8 flag", status_o, 8'h01);
    rd();
    wr(1'b0, 8'h40);
    tick_i = 1'b1; cyc(); tick_i = 1'b0;
    check("R8 disabled no wake", pdown_o, 1);
    rd();
    supply_ok_i = 1'b1; cyc(); supply_ok_i = 1'b0;
    check("R9 supply pdown", pdown_o, 0);
    check("R9 supply pse", pse_o, 1);
    supply_ok_i = 1'b1; ctl_wr_i = 1'b1; ctl_sel_i = 1'b0; ctl_wdata_i = 8'h40;
    cyc();
    supply_ok_i = 1'b0; ctl_wr_i = 1'b0; ctl_wdata_i = 8'h00;
    check("R10 wake wins pdown", pdown_o, 0);
    check("R10 wake wins pse", pse_o, 1);
    check("R11 spare bits", status_o & 8'hE8, 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_periodic();
    t_pfail();
    t_alarm();
    t_pending();
    t_pdown();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule